// File: doc/BRIEF.md
# Switchable Recency Victim Selector

This block models the replacement bookkeeping of a small set-associative cache so that two victim policies can be compared on the same stream of references. It keeps, for every set, a valid bit, a stored tag and a recency rank for each way. Each reference names a set and a tag. The block looks the tag up and answers with hit or miss and the way involved. On a miss it writes the tag into a way chosen by the active policy. The policy is either evict-oldest (LRU) or evict-newest (MRU). Two running counters total the hits and the misses. No data is stored and no memory traffic is produced.

References enter through a valid/ready request channel. Results leave through a valid/ready response channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the response channel from the next cycle. The result is held unchanged until `resp_ready` is seen high. While a result is held and `resp_ready` is low, `req_ready` stays low, so back-pressure on the response side stalls the request side. The policy pin, the synchronous clear and the counters are plain signals with no handshake.

Top module: `repl_unit`

## Requirements
- R1: After reset, or one cycle after `clr` is high, both counters read 0, `resp_valid` is 0 and every way of every set is empty. `req_ready` is low while `clr` is high.
- R2: A request whose tag is stored in its set returns `resp_hit`=1 and the way that holds the tag. It adds 1 to `hit_count` and changes no stored tag.
- R3: A miss in a set that still has an empty way fills the lowest-numbered empty way, whatever the policy.
- R4: With `policy`=0 (LRU), a miss in a full set replaces the way referenced longest ago.
- R5: With `policy`=1 (MRU), a miss in a full set replaces the way referenced most recently.
- R6: The way a request touches becomes the most recent one, on a hit and on a fill. Within each set the ranks always form a permutation of 0 to WAYS-1.
- R7: On an empty 3-way set, the stream A,B,A,C,D,A,D,C,A,C gives 4 misses under LRU and 5 misses under MRU.
- R8: On an empty 3-way set, the stream A,B,C,D,A,B,C,D,A,B gives 10 misses under LRU and 6 under MRU.
- R9: The result of a request accepted at one edge is valid from that edge on. It stays stable while `resp_ready` is low, and no new request is taken meanwhile.
- R10: The policy is sampled only on the edge where a request is accepted. Changing `policy` between requests leaves the stored state unchanged.
- R11: Sets are independent: requests to one set change neither the contents nor the ranks of another set.
- R12: Outside a clear, the sum of `hit_count` and `miss_count` grows by exactly one for each accepted request and is otherwise constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of contents, ranks, counters and pending result |
| policy | input | 1 | 0 = evict least recent, 1 = evict most recent |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_set | input | SET_W | Set index of the reference |
| req_tag | input | TAG_W | Tag of the reference |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Result is consumed this cycle |
| resp_hit | output | 1 | 1 on hit, 0 on miss |
| resp_way | output | WAY_W | Way that hit or was filled |
| hit_count | output | CNT_W | Hits since the last reset or clear |
| miss_count | output | CNT_W | Misses since the last reset or clear |

## Verification
Some properties are checked on every cycle. The ranks of every set must stay a permutation. A tag may match in at most one way. A stalled result must hold still. The counter sum may move by at most one per cycle. A clear must leave zeroed counters and no pending result.

Other properties need the bench's scenarios. These are the choice of victim under each policy, the fill order into empty ways, the miss totals of the two reference streams and set independence. Only a scenario can show them, because each one depends on the history of earlier references.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic {
    POL_LRU = 1'b0,
    POL_MRU = 1'b1
  } policy_e;
endpackage

// File: rtl/repl_tag_match.sv
module repl_tag_match #(
  parameter int WAYS  = 3,
  parameter int TAG_W = 8,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            match,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = valid[g] && (tags[g] == tag);
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i] && !hit) begin
        hit = 1'b1;
        way = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel
  import repl_pkg::*;
#(
  parameter int WAYS  = 3,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][WAY_W-1:0] ranks,
  input  policy_e                    mode,
  output logic [WAY_W-1:0]           way
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic             have_empty;
  logic [WAY_W-1:0] want_rank;

  assign want_rank = (mode == POL_MRU) ? '0 : OLDEST;

  always_comb begin
    have_empty = 1'b0;
    way        = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid[i] && !have_empty) begin
        have_empty = 1'b1;
        way        = WAY_W'(i);
      end
    end
    if (!have_empty) begin
      for (int i = 0; i < WAYS; i++) begin
        if (ranks[i] == want_rank) way = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/repl_unit.sv
module repl_unit
  import repl_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int WAYS     = 3,
  parameter int TAG_W    = 8,
  parameter int CNT_W    = 16,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             policy,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic             resp_hit,
  output logic [WAY_W-1:0] resp_way,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  logic [NUM_SETS-1:0][WAYS-1:0]            valid_q;
  logic [NUM_SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [NUM_SETS-1:0][WAYS-1:0][WAY_W-1:0] rank_q;

  logic [WAYS-1:0]  lk_match;
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;
  logic [WAY_W-1:0] vic_way;
  logic [WAY_W-1:0] tgt_way;
  logic [WAY_W-1:0] tgt_rank;
  logic             accept;
  policy_e          mode_now;

  assign mode_now  = policy_e'(policy);
  assign req_ready = !clr && (!resp_valid || resp_ready);
  assign accept    = req_valid && req_ready;

  repl_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .valid (valid_q[req_set]),
    .tags  (tag_q[req_set]),
    .tag   (req_tag),
    .match (lk_match),
    .hit   (lk_hit),
    .way   (lk_way)
  );

  repl_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid (valid_q[req_set]),
    .ranks (rank_q[req_set]),
    .mode  (mode_now),
    .way   (vic_way)
  );

  assign tgt_way  = lk_hit ? lk_way : vic_way;
  assign tgt_rank = rank_q[req_set][tgt_way];

  // Set contents and recency ranks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          rank_q[s][w]  <= WAY_W'(w);
        end
      end
    end else if (clr) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          rank_q[s][w]  <= WAY_W'(w);
        end
      end
    end else if (accept) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == tgt_way) begin
          rank_q[req_set][w] <= '0;
        end else if (rank_q[req_set][w] < tgt_rank) begin
          rank_q[req_set][w] <= rank_q[req_set][w] + 1'b1;
        end
      end
      if (!lk_hit) begin
        valid_q[req_set][tgt_way] <= 1'b1;
        tag_q[req_set][tgt_way]   <= req_tag;
      end
    end
  end

  // Response register and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else if (clr) begin
      resp_valid <= 1'b0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (accept) begin
        resp_valid <= 1'b1;
        resp_hit   <= lk_hit;
        resp_way   <= tgt_way;
        if (lk_hit) hit_count <= hit_count + 1'b1;
        else        miss_count <= miss_count + 1'b1;
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end

  // R6
  genvar gs, gr, gw;
  generate
    for (gs = 0; gs < NUM_SETS; gs++) begin : g_set_chk
      for (gr = 0; gr < WAYS; gr++) begin : g_rank_chk
        logic [WAYS-1:0] holds_r;
        for (gw = 0; gw < WAYS; gw++) begin : g_way
          assign holds_r[gw] = (rank_q[gs][gw] == WAY_W'(gr));
        end
        // R6
        rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
          $countones(holds_r) == 1);
      end
    end
  endgenerate

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready && !clr) |=> (resp_valid && $stable(resp_hit) && $stable(resp_way)));

  logic [CNT_W:0] cnt_sum;
  assign cnt_sum = {1'b0, hit_count} + {1'b0, miss_count};

  // R12
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_sum == $past(cnt_sum) || cnt_sum == $past(cnt_sum) + 1'b1));

  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hit_count == '0 && miss_count == '0 && !resp_valid));
endmodule

// File: tb/repl_unit_test.sv
module repl_unit_test;
  localparam int SET_W = 2;
  localparam int WAY_W = 2;
  localparam int TAG_W = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic policy = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SET_W-1:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic resp_valid;
  logic resp_ready = 1'b1;
  logic resp_hit;
  logic [WAY_W-1:0] resp_way;
  logic [CNT_W-1:0] hit_count;
  logic [CNT_W-1:0] miss_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  repl_unit uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .policy(policy),
    .req_valid(req_valid), .req_ready(req_ready), .req_set(req_set), .req_tag(req_tag),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit), .resp_way(resp_way),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic access(input int s, input int t, input logic m, output logic h, output int w);
    @(negedge clk);
    req_set = SET_W'(s); req_tag = TAG_W'(t); policy = m; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    h = resp_hit; w = int'(resp_way);
    chk(resp_valid, "R9 resp_valid after accept", int'(resp_valid), 1);
  endtask

  task automatic expect_acc(input int s, input int t, input logic m, input logic eh, input int ew, input string req);
    logic h; int w;
    access(s, t, m, h, w);
    chk(h == eh, req, int'(h), int'(eh));
    chk(w == ew, req, w, ew);
  endtask

  task automatic test_reset();
    chk(hit_count == 0 && miss_count == 0, "R1 counters at reset", int'(hit_count) + int'(miss_count), 0);
    chk(!resp_valid, "R1 resp_valid at reset", int'(resp_valid), 0);
    chk(req_ready, "R1 req_ready at reset", int'(req_ready), 1);
  endtask

  task automatic test_fill_hit();
    do_clear();
    expect_acc(0, 8'h0A, 1'b1, 1'b0, 0, "R3 first fill way0 (MRU mode)");
    expect_acc(0, 8'h0B, 1'b0, 1'b0, 1, "R3 second fill way1");
    expect_acc(0, 8'h0C, 1'b1, 1'b0, 2, "R3 third fill way2");
    expect_acc(0, 8'h0B, 1'b0, 1'b1, 1, "R2 hit on B way1");
    chk(hit_count == 1 && miss_count == 3, "R12 counters after 4 refs", int'(hit_count), 1);
  endtask

  task automatic test_lru_victim();
    do_clear();
    expect_acc(0, 1, 1'b0, 1'b0, 0, "R3 fill");
    expect_acc(0, 2, 1'b0, 1'b0, 1, "R3 fill");
    expect_acc(0, 3, 1'b0, 1'b0, 2, "R3 fill");
    expect_acc(0, 1, 1'b0, 1'b1, 0, "R6 hit refreshes way0");
    expect_acc(0, 4, 1'b0, 1'b0, 1, "R4 LRU evicts way1");
    expect_acc(0, 2, 1'b0, 1'b0, 2, "R4 LRU evicts way2");
  endtask

  task automatic test_mru_victim();
    do_clear();
    expect_acc(0, 1, 1'b1, 1'b0, 0, "R3 fill");
    expect_acc(0, 2, 1'b1, 1'b0, 1, "R3 fill");
    expect_acc(0, 3, 1'b1, 1'b0, 2, "R3 fill");
    expect_acc(0, 1, 1'b1, 1'b1, 0, "R6 hit makes way0 newest");
    expect_acc(0, 4, 1'b1, 1'b0, 0, "R5 MRU evicts way0");
    expect_acc(0, 2, 1'b1, 1'b1, 1, "R5 tag 2 still resident");
  endtask

  task automatic test_mode_between();
    do_clear();
    expect_acc(0, 1, 1'b0, 1'b0, 0, "R3 fill");
    expect_acc(0, 2, 1'b0, 1'b0, 1, "R3 fill");
    expect_acc(0, 3, 1'b0, 1'b0, 2, "R3 fill");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); policy = ~policy;
    end
    expect_acc(0, 4, 1'b0, 1'b0, 0, "R10 idle mode toggles leave LRU order");
  endtask

  task automatic run_stream(input int refs[10], input logic m, input int exp_miss, input string req);
    int misses = 0;
    logic h; int w;
    do_clear();
    for (int i = 0; i < 10; i++) begin
      access(0, refs[i], m, h, w);
      if (!h) misses++;
    end
    chk(misses == exp_miss, req, misses, exp_miss);
    chk(int'(miss_count) == exp_miss, req, int'(miss_count), exp_miss);
    chk(int'(hit_count) + int'(miss_count) == 10, "R12 counter sum", int'(hit_count) + int'(miss_count), 10);
  endtask

  task automatic test_streams();
    int s1[10] = '{1, 2, 1, 3, 4, 1, 4, 3, 1, 3};
    int s2[10] = '{1, 2, 3, 4, 1, 2, 3, 4, 1, 2};
    run_stream(s1, 1'b0, 4, "R7 LRU misses");
    run_stream(s1, 1'b1, 5, "R7 MRU misses");
    run_stream(s2, 1'b0, 10, "R8 LRU misses");
    run_stream(s2, 1'b1, 6, "R8 MRU misses");
  endtask

  task automatic test_sets();
    do_clear();
    expect_acc(1, 7, 1'b0, 1'b0, 0, "R11 fill set1");
    expect_acc(1, 8, 1'b0, 1'b0, 1, "R11 fill set1");
    expect_acc(2, 7, 1'b0, 1'b0, 0, "R11 set2 empty despite set1");
    expect_acc(1, 7, 1'b0, 1'b1, 0, "R11 set1 kept tag");
  endtask

  task automatic test_backpressure();
    logic [WAY_W-1:0] held;
    do_clear();
    expect_acc(0, 5, 1'b0, 1'b0, 0, "R3 fill");
    @(negedge clk);
    resp_ready = 1'b0;
    req_set = '0; req_tag = 8'd6; policy = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    chk(resp_valid && !resp_hit && resp_way == 1, "R9 first result", int'(resp_way), 1);
    req_tag = 8'd5;
    held = resp_way;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!req_ready, "R9 req_ready low while stalled", int'(req_ready), 0);
      chk(resp_valid && resp_way == held, "R9 result held", int'(resp_way), int'(held));
    end
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid && resp_hit && resp_way == 0, "R9 next result after release", int'(resp_way), 0);
    chk(miss_count == 2 && hit_count == 1, "R12 one count per request", int'(miss_count), 2);
    @(negedge clk);
    chk(!resp_valid, "R9 result drained", int'(resp_valid), 0);
  endtask

  task automatic test_clear();
    @(negedge clk); clr = 1'b1; req_valid = 1'b1; req_tag = 8'd9; req_set = '0;
    #1;
    chk(!req_ready, "R1 req_ready low during clear", int'(req_ready), 0);
    @(negedge clk); clr = 1'b0; req_valid = 1'b0;
    chk(hit_count == 0 && miss_count == 0 && !resp_valid, "R1 cleared state", int'(miss_count), 0);
    expect_acc(0, 5, 1'b0, 1'b0, 0, "R1 set empty after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_fill_hit();
    test_lru_victim();
    test_mru_victim();
    test_mode_between();
    test_streams();
    test_sets();
    test_backpressure();
    test_clear();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule